// File: doc/BRIEF.md
# Converter Standby and Output-Valid Sequencer

This block sequences the digital section of an audio converter into and out of low-power standby. It watches an already synchronized, active-low standby level and walks a five-state machine: RUN, POWERING_DOWN, STANDBY, WAKING and SETTLING. Both the entry into standby and the restart take a fixed number of system clocks. In that time the block steps the enables for the internal logic clock, for the serial-port drivers and for the overload flag output.

After the restart, the serial pins drive again, but the serial data line is forced low. This holds until the decimation chain has seen enough sample periods to produce trustworthy data. The settle time is 1024 sample strobes with the high-pass filter off and 8192 with it on. The sample strobe is one clock wide and occurs once per sample period, which is 256 system clocks in normal use. Only after the settle time does the block raise its data-valid flag.

The transitions are as follows:
- RUN goes to POWERING_DOWN when the level falls.
- POWERING_DOWN goes to STANDBY, or to WAKING if the level is high again, once its clock count ends.
- STANDBY goes to WAKING when the level rises.
- WAKING goes to SETTLING, or back to POWERING_DOWN if the level is low, once its clock count ends.
- SETTLING goes to RUN after the strobe count, or to POWERING_DOWN at once if the level falls.

Top module: `adc_stby_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block is in STANDBY. The output vector {clk_en, pin_oe, sdo_zero, ovl_en, data_valid} reads 00100.
- R2: In RUN (vector 11011), a low standby level moves the block to POWERING_DOWN at the next clock edge. Its vector is 10100: the clock stays on, while the pins, the overload output and data-valid are off.
- R3: POWERING_DOWN lasts exactly SEQ_CYCLES (default 32) clock edges. If the level is still low, the block then enters STANDBY and clk_en falls.
- R4: STANDBY keeps vector 00100 for as long as the level stays low.
- R5: A high level in STANDBY moves the block to WAKING (vector 10100) at the next edge. WAKING lasts exactly SEQ_CYCLES edges.
- R6: SETTLING has vector 11110: the pins drive, the data line is forced low and the overload output is enabled. It advances only on sample strobes, never on bare clocks.
- R7: With the high-pass enable low, SETTLING ends at the edge that samples the 1024th strobe, and the block enters RUN.
- R8: With the high-pass enable high, SETTLING needs 8192 strobes. The enable is taken in the last cycle before SETTLING, and changes during SETTLING have no effect.
- R9: A level change during POWERING_DOWN or WAKING does not cut the count short. When the count ends, the level is evaluated: high leads to WAKING, low leads to POWERING_DOWN.
- R10: A low level during SETTLING enters POWERING_DOWN at the next edge. The strobe count restarts from zero on the next SETTLING.
- R11: data_valid is high only in RUN, and only with all enables on and the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256 times the sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Synchronized standby level, low requests standby |
| hp_en | input | 1 | High-pass filter enabled, selects the long settle |
| smp_stb | input | 1 | One-clock strobe once per sample period |
| clk_en | output | 1 | Enable for the internal logic clock |
| pin_oe | output | 1 | Drive enable for the serial clock, word select and data pins |
| sdo_zero | output | 1 | Forces the serial data line low |
| ovl_en | output | 1 | Overload output enable; when low the flag is forced low |
| data_valid | output | 1 | Output data is trustworthy |

## Verification
The standby level is driven in four ways: as clean long periods, as a short low pulse inside POWERING_DOWN, as a drop inside WAKING, and as a drop inside SETTLING. The clean periods pin down the exact 32-edge length of both timed phases. The short pulse and the WAKING drop show that a count is finished before the level is evaluated. The SETTLING drop shows the immediate exit and the restart of the strobe count. The settle phase is fed sparse strobes with idle clocks between them, under both filter settings. It is also run with the filter enable flipped midway, which distinguishes counting strobes from counting clocks and shows that the filter choice is frozen at entry.

// File: rtl/adc_stby_pkg.sv
package adc_stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_PDOWN    = 3'd1,
        ST_STANDBY  = 3'd2,
        ST_WAKING   = 3'd3,
        ST_SETTLING = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic clk_en;
        logic pin_oe;
        logic sdo_zero;
        logic ovl_en;
        logic data_valid;
    } seq_out_t;

endpackage

// File: rtl/seq_cycle_timer.sv
module seq_cycle_timer #(
    parameter int SEQ_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(SEQ_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SEQ_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_settle_counter.sv
module seq_settle_counter #(
    parameter int SETTLE_PLAIN = 1024,
    parameter int SETTLE_HPF   = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hp_en,
    input  logic smp_stb,
    output logic done
);
    localparam int MAXN = (SETTLE_HPF > SETTLE_PLAIN) ? SETTLE_HPF : SETTLE_PLAIN;
    localparam int SW   = $clog2(MAXN + 1);
    localparam logic [SW-1:0] LAST_PLAIN = SW'(SETTLE_PLAIN - 1);
    localparam logic [SW-1:0] LAST_HPF   = SW'(SETTLE_HPF - 1);

    logic [SW-1:0] cnt_q;
    logic          hp_q;
    logic [SW-1:0] last;

    assign last = hp_q ? LAST_HPF : LAST_PLAIN;
    assign done = run && smp_stb && (cnt_q == last);

    // Filter choice follows the input until settling starts, then freezes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hp_q <= 1'b0;
        end else if (!run) begin
            hp_q <= hp_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else if (smp_stb) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import adc_stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_n,
    input  logic       tmr_done,
    input  logic       settle_done,
    output logic       tmr_run,
    output logic       settle_run,
    output seq_out_t   outs
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!stby_n) state_d = ST_PDOWN;
            end
            ST_PDOWN: begin
                if (tmr_done) state_d = stby_n ? ST_WAKING : ST_STANDBY;
            end
            ST_STANDBY: begin
                if (stby_n) state_d = ST_WAKING;
            end
            ST_WAKING: begin
                if (tmr_done) state_d = stby_n ? ST_SETTLING : ST_PDOWN;
            end
            ST_SETTLING: begin
                if (!stby_n)         state_d = ST_PDOWN;
                else if (settle_done) state_d = ST_RUN;
            end
            default: state_d = ST_STANDBY;
        endcase
    end

    assign tmr_run    = (state_q == ST_PDOWN) || (state_q == ST_WAKING);
    assign settle_run = (state_q == ST_SETTLING);

    always_comb begin
        outs = '{clk_en: 1'b0, pin_oe: 1'b0, sdo_zero: 1'b1,
                 ovl_en: 1'b0, data_valid: 1'b0};
        unique case (state_q)
            ST_RUN: begin
                outs.clk_en     = 1'b1;
                outs.pin_oe     = 1'b1;
                outs.sdo_zero   = 1'b0;
                outs.ovl_en     = 1'b1;
                outs.data_valid = 1'b1;
            end
            ST_PDOWN, ST_WAKING: begin
                outs.clk_en = 1'b1;
            end
            ST_STANDBY: begin
                outs.clk_en = 1'b0;
            end
            ST_SETTLING: begin
                outs.clk_en = 1'b1;
                outs.pin_oe = 1'b1;
                outs.ovl_en = 1'b1;
            end
            default: begin
                outs.clk_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/adc_stby_seq.sv
module adc_stby_seq
    import adc_stby_pkg::*;
#(
    parameter int SEQ_CYCLES   = 32,
    parameter int SETTLE_PLAIN = 1024,
    parameter int SETTLE_HPF   = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_n,
    input  logic hp_en,
    input  logic smp_stb,
    output logic clk_en,
    output logic pin_oe,
    output logic sdo_zero,
    output logic ovl_en,
    output logic data_valid
);
    logic     tmr_run, tmr_done;
    logic     settle_run, settle_done;
    seq_out_t outs;

    seq_cycle_timer #(.SEQ_CYCLES(SEQ_CYCLES)) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tmr_run),
        .done (tmr_done)
    );

    seq_settle_counter #(
        .SETTLE_PLAIN(SETTLE_PLAIN),
        .SETTLE_HPF  (SETTLE_HPF)
    ) settle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (settle_run),
        .hp_en  (hp_en),
        .smp_stb(smp_stb),
        .done   (settle_done)
    );

    seq_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_n     (stby_n),
        .tmr_done   (tmr_done),
        .settle_done(settle_done),
        .tmr_run    (tmr_run),
        .settle_run (settle_run),
        .outs       (outs)
    );

    assign clk_en     = outs.clk_en;
    assign pin_oe     = outs.pin_oe;
    assign sdo_zero   = outs.sdo_zero;
    assign ovl_en     = outs.ovl_en;
    assign data_valid = outs.data_valid;
endmodule

// File: rtl/adc_stby_seq_chk.sv
module adc_stby_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic stby_n,
    input logic clk_en,
    input logic pin_oe,
    input logic sdo_zero,
    input logic ovl_en,
    input logic data_valid
);
    AST_VALID_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (clk_en && pin_oe && ovl_en && !sdo_zero)); // R11

    AST_IDLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!pin_oe && !ovl_en && sdo_zero)); // R4

    AST_RUN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !stby_n) |=> (clk_en && !pin_oe && !ovl_en && !data_valid)); // R2

    AST_STBY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && stby_n) |=> (clk_en && !pin_oe)); // R5

    AST_SETTLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !data_valid && !stby_n) |=> (!pin_oe && clk_en)); // R10

    AST_PINS_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !data_valid) |-> sdo_zero); // R6
endmodule

bind adc_stby_seq adc_stby_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_n    (stby_n),
    .clk_en    (clk_en),
    .pin_oe    (pin_oe),
    .sdo_zero  (sdo_zero),
    .ovl_en    (ovl_en),
    .data_valid(data_valid)
);

// File: tb/adc_stby_seq_tb_top.sv
module adc_stby_seq_tb_top;
    localparam logic [4:0] V_RUN  = 5'b11011;
    localparam logic [4:0] V_TIME = 5'b10100; // POWERING_DOWN and WAKING
    localparam logic [4:0] V_STBY = 5'b00100;
    localparam logic [4:0] V_SET  = 5'b11110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_n = 1'b0;
    logic hp_en = 1'b0;
    logic smp_stb = 1'b0;
    logic clk_en, pin_oe, sdo_zero, ovl_en, data_valid;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    adc_stby_seq dut_i (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .hp_en(hp_en),
        .smp_stb(smp_stb), .clk_en(clk_en), .pin_oe(pin_oe),
        .sdo_zero(sdo_zero), .ovl_en(ovl_en), .data_valid(data_valid)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {clk_en, pin_oe, sdo_zero, ovl_en, data_valid};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // n strobes, each one clock wide followed by three idle clocks
    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            smp_stb = 1'b1;
            tick(1);
            smp_stb = 1'b0;
            tick(3);
        end
    endtask

    task automatic t_reset;
        check("R1 during reset", V_STBY);
        rst_n = 1'b1;
        tick(1);
        check("R1 after reset", V_STBY);
        tick(10);
        check("R4 standby held", V_STBY);
    endtask

    // from STANDBY: wake and reach SETTLING
    task automatic t_wake;
        stby_n = 1'b1;
        tick(1);
        check("R5 waking entered", V_TIME);
        tick(31);
        check("R5 waking last cycle", V_TIME);
        tick(1);
        check("R6 settling entered", V_SET);
    endtask

    task automatic t_settle_plain;
        hp_en = 1'b0;
        t_wake();
        tick(40);
        check("R6 bare clocks do not settle", V_SET);
        strobes(1023);
        check("R7 1023 strobes still settling", V_SET);
        smp_stb = 1'b1;
        tick(1);
        smp_stb = 1'b0;
        check("R7 run after 1024th strobe", V_RUN);
        check("R11 valid in run", V_RUN);
    endtask

    task automatic t_pdown;
        stby_n = 1'b0;
        tick(1);
        check("R2 powering down entered", V_TIME);
        tick(31);
        check("R3 powering down last cycle", V_TIME);
        tick(1);
        check("R3 standby reached", V_STBY);
        tick(20);
        check("R4 standby stays", V_STBY);
    endtask

    task automatic t_settle_hpf;
        hp_en = 1'b1;
        t_wake();
        tick(2);
        hp_en = 1'b0;
        strobes(1024);
        check("R8 hp frozen, 1024 not enough", V_SET);
        strobes(8191 - 1024);
        check("R8 8191 strobes still settling", V_SET);
        smp_stb = 1'b1;
        tick(1);
        smp_stb = 1'b0;
        check("R8 run after 8192nd strobe", V_RUN);
    endtask

    task automatic t_short_low;
        stby_n = 1'b0;
        tick(1);
        stby_n = 1'b1;
        tick(31);
        check("R9 pulse: count still running", V_TIME);
        tick(1);
        check("R9 pulse: no standby, waking", V_TIME);
        tick(31);
        check("R9 pulse: waking last cycle", V_TIME);
        tick(1);
        check("R9 pulse: settling", V_SET);
        strobes(1024);
        check("R9 pulse: back to run", V_RUN);
    endtask

    task automatic t_wake_abort;
        stby_n = 1'b1;
        tick(5);
        stby_n = 1'b0;
        tick(27);
        check("R9 waking finishes count", V_TIME);
        tick(1);
        check("R9 powering down after waking", V_TIME);
        tick(31);
        check("R9 powering down last cycle", V_TIME);
        tick(1);
        check("R9 standby after abort", V_STBY);
    endtask

    task automatic t_settle_abort;
        hp_en = 1'b0;
        t_wake();
        strobes(500);
        stby_n = 1'b0;
        tick(1);
        check("R10 settling exits at once", V_TIME);
        tick(32);
        check("R10 standby after exit", V_STBY);
        t_wake();
        strobes(1023);
        check("R10 count restarted", V_SET);
        strobes(1);
        check("R10 run after full count", V_RUN);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_settle_plain();
        t_pdown();
        t_settle_hpf();
        t_short_low();
        t_pdown();
        t_wake_abort();
        t_settle_abort();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule